// File: doc/BRIEF.md
# Processor Status and Exception Control Registers

This block keeps the machine state that a 32-bit soft processor consults around traps: a status word with three live flags (interrupt enable, break in progress, exception in progress), a cause word, a faulting-address word and a delay-slot branch-target word. The decode stage presents one special-register operation per cycle. The operation can be a move to a special register, a move from one, an atomic read-then-set or read-then-clear of status flags under an immediate mask, or one of three return instructions. Each return restores a status flag and computes a redirect address.

Trap entries arrive on separate strobes from logic outside the block, which also detects their causes. The block applies them with a fixed priority and produces a registered redirect request one cycle later. The redirect carries the vector for the trap, the computed return target, or the restart address 0x0 while reset is held. The current status word leaves the block as a port, so the pipeline can gate interrupts and observe nesting.

Top module: `sys_state_regs`

## Requirements
- R1: While rst_n is low at a clock edge, status_flags becomes 0, redirect_valid becomes 1 and redirect_addr becomes 0x0. The cause, fault-address and slot-target words clear to 0.
- R2: A move-from (op_sel 1) returns the addressed word on rd_data in the same cycle. The addresses are 0x0001 for status, 0x0003 for fault address, 0x0005 for cause and 0x000B for slot target. rd_data is 0 whenever no read-type operation is accepted.
- R3: A move-to (op_sel 0) at address 0x0001 loads status_flags with src_val masked to the implemented bits. Those bits are interrupt enable (bit 1), break in progress (bit 3) and exception in progress (bit 9), counting from the least significant bit. All other status bits always read 0.
- R4: A move-to any other address changes no register, and a move-from any address outside the four listed returns 0.
- R5: A read-then-set (op_sel 2) returns the old status on rd_data in the same cycle. On the next edge it ORs the implemented bits of imm_val into status. Immediate bits at unimplemented positions have no effect.
- R6: A read-then-clear (op_sel 3) returns the old status on rd_data in the same cycle. On the next edge it clears every implemented status bit whose imm_val bit is 1.
- R7: Exception entry sets status bit 9 and loads the cause word with exc_code in its low bits and exc_in_slot at bit 12. It also loads the fault-address word from exc_fault_addr, and the next cycle shows redirect_valid with redirect_addr 0x20.
- R8: On exception entry the slot-target word loads exc_slot_target only when exc_in_slot is 1. Otherwise it keeps its value.
- R9: Interrupt entry is honoured only while status bit 1 is 1. It clears bit 1 and redirects to 0x10. When bit 1 is 0, irq_take has no effect.
- R10: Break entry sets status bit 3 and redirects to 0x18.
- R11: Return-from-interrupt (op_sel 4) sets bit 1, return-from-break (op_sel 5) clears bit 3 and return-from-exception (op_sel 6) clears bit 9. Each redirects to src_val plus imm_val sign-extended to 32 bits. op_sel 7 does nothing.
- R12: The priority is exception, then break, then an honoured interrupt, then the decoded operation. A lower-priority request in the same cycle is dropped entirely, and rd_data reads 0 in that case.
- R13: redirect_valid is 0 in every cycle that follows a cycle with no trap entry and no return instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_en | input | 1 | A special-register operation is presented this cycle |
| op_sel | input | 3 | Operation code (0 move-to, 1 move-from, 2 read-set, 3 read-clear, 4/5/6 returns, 7 none) |
| reg_addr | input | 14 | Special-register address for move-to / move-from |
| src_val | input | 32 | Source register value (move-to data or return base) |
| imm_val | input | 16 | Immediate: flag mask or return offset |
| exc_take | input | 1 | Exception entry strobe |
| exc_code | input | 5 | Exception cause code |
| exc_in_slot | input | 1 | Faulting instruction sat in a branch delay slot |
| exc_fault_addr | input | 32 | Load/store address that faulted |
| exc_slot_target | input | 32 | Target of the branch owning the delay slot |
| irq_take | input | 1 | Interrupt entry request |
| brk_take | input | 1 | Break entry strobe |
| rd_data | output | 32 | Read result for move-from and read-set/clear |
| status_flags | output | 32 | Current status word |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_addr | output | 32 | Redirect target address |

## Verification
The bench builds the block with its default parameters: a 5-bit cause code, a 16-bit immediate and the slot-target word present. With these values the three implemented status bits make the full 8 by 8 grid of starting states and masks cheap to sweep for both read-then-set and read-then-clear, with noise at every unimplemented immediate bit. The 5-bit code allows all 32 cause codes to be taken with alternating delay-slot flags. A sweep over the low address space plus an aliasing high address covers every decoded and undecoded special-register slot. The sweeps also pile up same-cycle collisions of entries and operations to exercise the priority order.

// File: rtl/sys_state_pkg.sv
// Shared definitions for the status and exception control registers.
// Assumes status bit positions are counted from the least significant bit.
package sys_state_pkg;

    typedef enum logic [2:0] {
        OP_MOVE_TO   = 3'd0,
        OP_MOVE_FROM = 3'd1,
        OP_READ_SET  = 3'd2,
        OP_READ_CLR  = 3'd3,
        OP_RET_INT   = 3'd4,
        OP_RET_BRK   = 3'd5,
        OP_RET_EXC   = 3'd6,
        OP_NONE      = 3'd7
    } op_e;

    // Implemented status flag positions
    localparam int BIT_IE  = 1;
    localparam int BIT_BRK = 3;
    localparam int BIT_EXC = 9;

    // Special-register addresses
    localparam int SEL_STATUS = 'h0001;
    localparam int SEL_FAULT  = 'h0003;
    localparam int SEL_CAUSE  = 'h0005;
    localparam int SEL_TARGET = 'h000B;

    // One-hot winner of the per-cycle arbitration
    typedef struct packed {
        logic exc;
        logic brk;
        logic irq;
        logic op;
    } evt_t;

endpackage

// File: rtl/sys_state_arb.sv
// Picks at most one winner per cycle: exception, break, honoured interrupt,
// then the decoded operation. Assumes the trap strobes are single-cycle.
module sys_state_arb
    import sys_state_pkg::*;
(
    input  logic exc_take,
    input  logic brk_take,
    input  logic irq_take,
    input  logic ie_now,
    input  logic op_en,
    output evt_t evt
);

    // Fixed-priority selection; interrupts are masked by the enable flag
    always_comb begin
        evt = '0;
        if (exc_take)
            evt.exc = 1'b1;
        else if (brk_take)
            evt.brk = 1'b1;
        else if (irq_take && ie_now)
            evt.irq = 1'b1;
        else if (op_en)
            evt.op = 1'b1;
    end

endmodule

// File: rtl/sys_state_status.sv
// Status word: holds the three implemented flags and applies trap entries,
// moves, masked read-modify operations and returns. Assumes evt is one-hot.
module sys_state_status
    import sys_state_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  evt_t              evt,
    input  op_e               op,
    input  logic              wr_status,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm_val,
    output logic [DATA_W-1:0] status_q
);

    localparam logic [DATA_W-1:0] IMPL =
        DATA_W'((1 << BIT_IE) | (1 << BIT_BRK) | (1 << BIT_EXC));

    logic [DATA_W-1:0] mask_ext;
    logic [DATA_W-1:0] status_nxt;

    // Immediate mask restricted to implemented positions
    assign mask_ext = DATA_W'(imm_val) & IMPL;

    // Next-state selection for the status word
    always_comb begin
        status_nxt = status_q;
        if (evt.exc) begin
            status_nxt[BIT_EXC] = 1'b1;
        end else if (evt.brk) begin
            status_nxt[BIT_BRK] = 1'b1;
        end else if (evt.irq) begin
            status_nxt[BIT_IE] = 1'b0;
        end else if (evt.op) begin
            case (op)
                OP_MOVE_TO:  if (wr_status) status_nxt = src_val & IMPL;
                OP_READ_SET: status_nxt = status_q | mask_ext;
                OP_READ_CLR: status_nxt = status_q & ~mask_ext;
                OP_RET_INT:  status_nxt[BIT_IE]  = 1'b1;
                OP_RET_BRK:  status_nxt[BIT_BRK] = 1'b0;
                OP_RET_EXC:  status_nxt[BIT_EXC] = 1'b0;
                default:     status_nxt = status_q;
            endcase
        end
    end

    // Status register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= status_nxt;
    end

endmodule

// File: rtl/sys_state_capture.sv
// Captures cause, faulting address and (optionally) delay-slot branch target
// on exception entry. Assumes take_exc is already arbitrated.
module sys_state_capture #(
    parameter int DATA_W   = 32,
    parameter int CAUSE_W  = 5,
    parameter int SLOT_BIT = 12,
    parameter bit HAS_SLOT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_exc,
    input  logic [CAUSE_W-1:0] code,
    input  logic               in_slot,
    input  logic [DATA_W-1:0]  fault_addr,
    input  logic [DATA_W-1:0]  slot_target,
    output logic [DATA_W-1:0]  cause_q,
    output logic [DATA_W-1:0]  fault_q,
    output logic [DATA_W-1:0]  target_q
);

    logic [DATA_W-1:0] cause_nxt;

    // Assemble the cause word: code in the low bits, slot flag at SLOT_BIT
    always_comb begin
        cause_nxt = '0;
        cause_nxt[CAUSE_W-1:0] = code;
        cause_nxt[SLOT_BIT] = in_slot;
    end

    // Cause and fault-address registers load on every exception entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            fault_q <= '0;
        end else if (take_exc) begin
            cause_q <= cause_nxt;
            fault_q <= fault_addr;
        end
    end

    generate
        if (HAS_SLOT) begin : g_slot
            // Slot target loads only for faults inside a delay slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    target_q <= '0;
                else if (take_exc && in_slot)
                    target_q <= slot_target;
            end
        end else begin : g_no_slot
            assign target_q = '0;
        end
    endgenerate

endmodule

// File: rtl/sys_state_redirect.sv
// Registered fetch redirect: trap vectors, return targets, restart on reset.
// Assumes evt is one-hot and op carries the decoded operation.
module sys_state_redirect
    import sys_state_pkg::*;
#(
    parameter int                DATA_W  = 32,
    parameter int                IMM_W   = 16,
    parameter logic [DATA_W-1:0] RST_VEC = '0,
    parameter logic [DATA_W-1:0] IRQ_VEC = DATA_W'(32'h10),
    parameter logic [DATA_W-1:0] BRK_VEC = DATA_W'(32'h18),
    parameter logic [DATA_W-1:0] EXC_VEC = DATA_W'(32'h20)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  evt_t              evt,
    input  op_e               op,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm_val,
    output logic              valid_q,
    output logic [DATA_W-1:0] addr_q
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic              valid_nxt;
    logic [DATA_W-1:0] addr_nxt;
    logic [DATA_W-1:0] ret_target;
    logic              is_ret;

    // Return target: base plus sign-extended offset
    assign ret_target = src_val + {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
    assign is_ret = (op == OP_RET_INT) || (op == OP_RET_BRK) || (op == OP_RET_EXC);

    // Choose the redirect for this cycle's winning event
    always_comb begin
        valid_nxt = 1'b0;
        addr_nxt  = '0;
        if (evt.exc) begin
            valid_nxt = 1'b1;
            addr_nxt  = EXC_VEC;
        end else if (evt.brk) begin
            valid_nxt = 1'b1;
            addr_nxt  = BRK_VEC;
        end else if (evt.irq) begin
            valid_nxt = 1'b1;
            addr_nxt  = IRQ_VEC;
        end else if (evt.op && is_ret) begin
            valid_nxt = 1'b1;
            addr_nxt  = ret_target;
        end
    end

    // Redirect register; reset requests a restart at RST_VEC
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b1;
            addr_q  <= RST_VEC;
        end else begin
            valid_q <= valid_nxt;
            addr_q  <= addr_nxt;
        end
    end

endmodule

// File: rtl/sys_state_regs.sv
// Top of the status and exception control registers. Arbitrates trap entries
// against the decoded special-register operation, holds the status, cause,
// fault-address and slot-target words, and issues fetch redirects.
// Assumes one operation per cycle and single-cycle trap strobes.
module sys_state_regs
    import sys_state_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter int                IMM_W    = 16,
    parameter int                ADDR_W   = 14,
    parameter int                CAUSE_W  = 5,
    parameter int                SLOT_BIT = 12,
    parameter bit                HAS_SLOT = 1'b1,
    parameter logic [DATA_W-1:0] RST_VEC  = '0,
    parameter logic [DATA_W-1:0] IRQ_VEC  = DATA_W'(32'h10),
    parameter logic [DATA_W-1:0] BRK_VEC  = DATA_W'(32'h18),
    parameter logic [DATA_W-1:0] EXC_VEC  = DATA_W'(32'h20)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_en,
    input  logic [2:0]         op_sel,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  src_val,
    input  logic [IMM_W-1:0]   imm_val,
    input  logic               exc_take,
    input  logic [CAUSE_W-1:0] exc_code,
    input  logic               exc_in_slot,
    input  logic [DATA_W-1:0]  exc_fault_addr,
    input  logic [DATA_W-1:0]  exc_slot_target,
    input  logic               irq_take,
    input  logic               brk_take,
    output logic [DATA_W-1:0]  rd_data,
    output logic [DATA_W-1:0]  status_flags,
    output logic               redirect_valid,
    output logic [DATA_W-1:0]  redirect_addr
);

    op_e               op;
    evt_t              evt;
    logic              wr_status;
    logic [DATA_W-1:0] cause_w;
    logic [DATA_W-1:0] fault_w;
    logic [DATA_W-1:0] target_w;
    logic [DATA_W-1:0] sel_word;

    assign op        = op_e'(op_sel);
    assign wr_status = (reg_addr == ADDR_W'(SEL_STATUS));

    sys_state_arb u_arb (
        .exc_take (exc_take),
        .brk_take (brk_take),
        .irq_take (irq_take),
        .ie_now   (status_flags[BIT_IE]),
        .op_en    (op_en),
        .evt      (evt)
    );

    sys_state_status #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .op        (op),
        .wr_status (wr_status),
        .src_val   (src_val),
        .imm_val   (imm_val),
        .status_q  (status_flags)
    );

    sys_state_capture #(
        .DATA_W(DATA_W), .CAUSE_W(CAUSE_W), .SLOT_BIT(SLOT_BIT), .HAS_SLOT(HAS_SLOT)
    ) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_exc    (evt.exc),
        .code        (exc_code),
        .in_slot     (exc_in_slot),
        .fault_addr  (exc_fault_addr),
        .slot_target (exc_slot_target),
        .cause_q     (cause_w),
        .fault_q     (fault_w),
        .target_q    (target_w)
    );

    sys_state_redirect #(
        .DATA_W(DATA_W), .IMM_W(IMM_W), .RST_VEC(RST_VEC),
        .IRQ_VEC(IRQ_VEC), .BRK_VEC(BRK_VEC), .EXC_VEC(EXC_VEC)
    ) u_redirect (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .op      (op),
        .src_val (src_val),
        .imm_val (imm_val),
        .valid_q (redirect_valid),
        .addr_q  (redirect_addr)
    );

    // Address decode for move-from; undecoded addresses read zero
    always_comb begin
        sel_word = '0;
        if (reg_addr == ADDR_W'(SEL_STATUS))
            sel_word = status_flags;
        else if (reg_addr == ADDR_W'(SEL_FAULT))
            sel_word = fault_w;
        else if (reg_addr == ADDR_W'(SEL_CAUSE))
            sel_word = cause_w;
        else if (reg_addr == ADDR_W'(SEL_TARGET))
            sel_word = target_w;
    end

    // Read port: old status for read-modify, decoded word for move-from
    always_comb begin
        rd_data = '0;
        if (evt.op) begin
            case (op)
                OP_MOVE_FROM:             rd_data = sel_word;
                OP_READ_SET, OP_READ_CLR: rd_data = status_flags;
                default:                  rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/sys_state_regs_chk.sv
// Property checker for sys_state_regs, attached with bind below.
module sys_state_regs_chk
    import sys_state_pkg::*;
#(
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] IRQ_VEC = DATA_W'(32'h10),
    parameter logic [DATA_W-1:0] BRK_VEC = DATA_W'(32'h18),
    parameter logic [DATA_W-1:0] EXC_VEC = DATA_W'(32'h20)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_en,
    input logic [2:0]        op_sel,
    input logic              exc_take,
    input logic              irq_take,
    input logic              brk_take,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] status_flags,
    input logic              redirect_valid,
    input logic [DATA_W-1:0] redirect_addr
);

    localparam logic [DATA_W-1:0] IMPL =
        DATA_W'((1 << BIT_IE) | (1 << BIT_BRK) | (1 << BIT_EXC));

    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_flags & ~IMPL) == '0);

    p_rd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_en |-> rd_data == '0);

    p_exc_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> status_flags[BIT_EXC] && redirect_valid && redirect_addr == EXC_VEC);

    p_irq_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_take && !brk_take && irq_take && status_flags[BIT_IE]
        |=> !status_flags[BIT_IE] && redirect_valid && redirect_addr == IRQ_VEC);

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_take && !brk_take && irq_take && !status_flags[BIT_IE] && !op_en
        |=> $stable(status_flags) && !redirect_valid);

    p_brk_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_take && brk_take |=> status_flags[BIT_BRK] && redirect_addr == BRK_VEC);

    p_ret_exc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_take && !brk_take && !irq_take && op_en && op_sel == 3'd6
        |=> !status_flags[BIT_EXC] && redirect_valid);

    p_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_take && !brk_take && !irq_take && !op_en
        |=> !redirect_valid && $stable(status_flags));

endmodule

bind sys_state_regs sys_state_regs_chk #(
    .DATA_W(DATA_W), .IRQ_VEC(IRQ_VEC), .BRK_VEC(BRK_VEC), .EXC_VEC(EXC_VEC)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_en          (op_en),
    .op_sel         (op_sel),
    .exc_take       (exc_take),
    .irq_take       (irq_take),
    .brk_take       (brk_take),
    .rd_data        (rd_data),
    .status_flags   (status_flags),
    .redirect_valid (redirect_valid),
    .redirect_addr  (redirect_addr)
);

// File: tb/sys_state_regs_test.sv
module sys_state_regs_test;
    import sys_state_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_en = 1'b0;
    logic [2:0]  op_sel = 3'd7;
    logic [13:0] reg_addr = '0;
    logic [31:0] src_val = '0;
    logic [15:0] imm_val = '0;
    logic        exc_take = 1'b0;
    logic [4:0]  exc_code = '0;
    logic        exc_in_slot = 1'b0;
    logic [31:0] exc_fault_addr = '0;
    logic [31:0] exc_slot_target = '0;
    logic        irq_take = 1'b0;
    logic        brk_take = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] status_flags;
    logic        redirect_valid;
    logic [31:0] redirect_addr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] rd;
    logic [31:0] exp_tgt;

    always #2 clk = ~clk;

    sys_state_regs uut (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel),
        .reg_addr(reg_addr), .src_val(src_val), .imm_val(imm_val),
        .exc_take(exc_take), .exc_code(exc_code), .exc_in_slot(exc_in_slot),
        .exc_fault_addr(exc_fault_addr), .exc_slot_target(exc_slot_target),
        .irq_take(irq_take), .brk_take(brk_take), .rd_data(rd_data),
        .status_flags(status_flags), .redirect_valid(redirect_valid),
        .redirect_addr(redirect_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Spread a 3-bit index onto status bits 1, 3 and 9
    function automatic logic [31:0] spread(input int k);
        return (32'(k & 1) << 1) | (32'((k >> 1) & 1) << 3) | (32'((k >> 2) & 1) << 9);
    endfunction

    // Drive one cycle from a falling edge; sample rd_data before the rising
    // edge, return at the next falling edge with inputs cleared
    task automatic step(input logic e, input logic b, input logic i, input logic oe,
                        input logic [2:0] op, input logic [13:0] a,
                        input logic [31:0] s, input logic [15:0] im,
                        output logic [31:0] r);
        exc_take = e; brk_take = b; irq_take = i; op_en = oe;
        op_sel = op; reg_addr = a; src_val = s; imm_val = im;
        #1 r = rd_data;
        @(posedge clk);
        @(negedge clk);
        exc_take = 0; brk_take = 0; irq_take = 0; op_en = 0;
        op_sel = 3'd7; reg_addr = '0; src_val = '0; imm_val = '0;
    endtask

    task automatic put_status(input logic [31:0] v);
        logic [31:0] d;
        step(0, 0, 0, 1, OP_MOVE_TO, 14'h0001, v, 16'h0, d);
    endtask

    task automatic read_reg(input logic [13:0] a, output logic [31:0] r);
        step(0, 0, 0, 1, OP_MOVE_FROM, a, 32'h0, 16'h0, r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 status", status_flags, 32'h0);
        chk("R1 redirect_valid", 32'(redirect_valid), 32'h1);
        chk("R1 redirect_addr", redirect_addr, 32'h0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R13 valid after reset", 32'(redirect_valid), 32'h0);
        read_reg(14'h0003, rd); chk("R1 fault", rd, 32'h0);
        read_reg(14'h0005, rd); chk("R1 cause", rd, 32'h0);
        read_reg(14'h000B, rd); chk("R1 target", rd, 32'h0);
        chk("R2 idle rd_data", rd_data, 32'h0);

        // R3: move-to masks to implemented bits
        put_status(32'hFFFF_FFFF);
        chk("R3 all ones", status_flags, 32'h0000_020A);
        put_status(32'h0000_0208);
        chk("R3 pattern", status_flags, 32'h0000_0208);

        // R2/R4: address sweep, status holds 0x20A
        put_status(32'h0000_020A);
        for (int a = 0; a < 32; a++) begin
            read_reg(14'(a), rd);
            chk(a == 1 ? "R2 read status" : "R4 read other", rd, a == 1 ? 32'h20A : 32'h0);
        end
        read_reg(14'h2001, rd); chk("R4 aliased high address", rd, 32'h0);

        // R4: move-to other addresses ignored
        for (int k = 0; k < 5; k++) begin
            logic [13:0] wa;
            wa = (k == 0) ? 14'h0000 : (k == 1) ? 14'h0003 : (k == 2) ? 14'h0005 :
                 (k == 3) ? 14'h000B : 14'h2001;
            step(0, 0, 0, 1, OP_MOVE_TO, wa, 32'h0000_0000, 16'h0, rd);
            chk("R4 status untouched", status_flags, 32'h20A);
            read_reg(wa, rd);
            chk("R4 readback", rd, 32'h0);
        end

        // R5/R6: exhaustive set/clear over implemented bits with immediate noise
        for (int s = 0; s < 8; s++) begin
            for (int m = 0; m < 8; m++) begin
                logic [15:0] imm;
                imm = 16'(spread(m)) | 16'hFDF5;
                put_status(spread(s));
                step(0, 0, 0, 1, OP_READ_SET, 14'h0, 32'h0, imm, rd);
                chk("R5 old value", rd, spread(s));
                chk("R5 set result", status_flags, spread(s) | spread(m));
                put_status(spread(s));
                step(0, 0, 0, 1, OP_READ_CLR, 14'h0, 32'h0, 16'(spread(m)), rd);
                chk("R6 old value", rd, spread(s));
                chk("R6 clear result", status_flags, spread(s) & ~spread(m));
            end
        end

        // R7/R8: all cause codes, alternating delay-slot flag
        exp_tgt = 32'h0;
        for (int c = 0; c < 32; c++) begin
            logic sl;
            sl = c[0];
            put_status(32'h0000_0002);
            exc_code = 5'(c); exc_in_slot = sl;
            exc_fault_addr = 32'hA000_0000 + 32'(c * 4);
            exc_slot_target = 32'h0000_8000 + 32'(c);
            step(1, 0, 0, 0, OP_NONE, 14'h0, 32'h0, 16'h0, rd);
            if (sl) exp_tgt = 32'h0000_8000 + 32'(c);
            chk("R7 status", status_flags, 32'h0000_0202);
            chk("R7 redirect_valid", 32'(redirect_valid), 32'h1);
            chk("R7 redirect_addr", redirect_addr, 32'h20);
            read_reg(14'h0005, rd);
            chk("R7 cause", rd, 32'(c) | (32'(sl) << 12));
            chk("R13 after read", 32'(redirect_valid), 32'h0);
            read_reg(14'h0003, rd);
            chk("R7 fault", rd, 32'hA000_0000 + 32'(c * 4));
            read_reg(14'h000B, rd);
            chk("R8 slot target", rd, exp_tgt);
        end

        // R9: interrupt honoured and masked
        put_status(32'h0000_0002);
        step(0, 0, 1, 0, OP_NONE, 14'h0, 32'h0, 16'h0, rd);
        chk("R9 ie cleared", status_flags, 32'h0);
        chk("R9 redirect", redirect_addr, 32'h10);
        chk("R9 redirect_valid", 32'(redirect_valid), 32'h1);
        step(0, 0, 1, 0, OP_NONE, 14'h0, 32'h0, 16'h0, rd);
        chk("R9 masked status", status_flags, 32'h0);
        chk("R9 masked no redirect", 32'(redirect_valid), 32'h0);

        // R10: break entry
        step(0, 1, 0, 0, OP_NONE, 14'h0, 32'h0, 16'h0, rd);
        chk("R10 brk flag", status_flags, 32'h0000_0008);
        chk("R10 redirect", redirect_addr, 32'h18);

        // R11: returns
        put_status(32'h0000_0208);
        step(0, 0, 0, 1, OP_RET_INT, 14'h0, 32'h0000_1000, 16'hFFF0, rd);
        chk("R11 ret_int status", status_flags, 32'h20A);
        chk("R11 ret_int addr", redirect_addr, 32'h0000_0FF0);
        step(0, 0, 0, 1, OP_RET_BRK, 14'h0, 32'h0000_4000, 16'h0010, rd);
        chk("R11 ret_brk status", status_flags, 32'h202);
        chk("R11 ret_brk addr", redirect_addr, 32'h0000_4010);
        step(0, 0, 0, 1, OP_RET_EXC, 14'h0, 32'h8000_0000, 16'h7FFF, rd);
        chk("R11 ret_exc status", status_flags, 32'h002);
        chk("R11 ret_exc addr", redirect_addr, 32'h8000_7FFF);
        for (int k = 0; k < 8; k++) begin
            logic [15:0] im;
            logic [31:0] sv;
            im = 16'(k * 16'h2345);
            sv = 32'h0001_0000 * 32'(k) + 32'h100;
            step(0, 0, 0, 1, OP_RET_BRK, 14'h0, sv, im, rd);
            chk("R11 target sweep", redirect_addr, sv + {{16{im[15]}}, im});
        end
        step(0, 0, 0, 1, OP_NONE, 14'h0, 32'h1234, 16'h1, rd);
        chk("R11 op 7 status", status_flags, 32'h002);
        chk("R11 op 7 no redirect", 32'(redirect_valid), 32'h0);

        // R12: priority collisions
        put_status(32'h0000_0002);
        step(1, 1, 1, 1, OP_READ_SET, 14'h0, 32'h0, 16'hFFFF, rd);
        chk("R12 rd dropped", rd, 32'h0);
        chk("R12 exc wins status", status_flags, 32'h202);
        chk("R12 exc wins addr", redirect_addr, 32'h20);
        put_status(32'h0000_0002);
        step(0, 1, 1, 0, OP_NONE, 14'h0, 32'h0, 16'h0, rd);
        chk("R12 brk over irq status", status_flags, 32'h00A);
        chk("R12 brk over irq addr", redirect_addr, 32'h18);
        put_status(32'h0000_020A);
        step(0, 0, 1, 1, OP_MOVE_TO, 14'h0001, 32'h0, 16'h0, rd);
        chk("R12 irq over op status", status_flags, 32'h208);
        chk("R12 irq over op addr", redirect_addr, 32'h10);
        step(0, 0, 1, 1, OP_MOVE_TO, 14'h0001, 32'h0, 16'h0, rd);
        chk("R12 masked irq lets op through", status_flags, 32'h0);
        chk("R13 no redirect for move", 32'(redirect_valid), 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule